// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a bank of binary mutual-exclusion locks that several processors on one chip share through a simple register bus. Each lock sits in its own 32-bit word. A read of that word tests the lock and claims it as one indivisible step. The read returns 0 when the caller has just won the lock and 1 when another owner already holds it. The owner gives the lock back by writing zero to the same word.

A read-only status word tells software how many locks the bank holds. The count is a one-hot multiple of 32, placed in a four-bit field. The count is set by the parameter `NUM_LOCKS`, which may be 32, 64, 128 or 256. The bus has one port. Read data appears in the cycle after the read strobe.

Top module: `hwlock_bank`

## Requirements
- R1: A read strobe on the word of a free lock returns 0 on `rdData` one cycle later, and the lock is then taken.
- R2: A read strobe on the word of a taken lock returns 1 (bit 0 set, all other bits 0), and the lock stays taken.
- R3: A write of the value 0 to a lock word frees that lock. In the lock encoding, free is 0 and taken is 1.
- R4: Lock i is addressed at byte offset 0x800 + 4*i, for i from 0 to NUM_LOCKS-1. Lock words must be word aligned.
- R5: A read of byte offset 0x014 returns NUM_LOCKS/32 in bits 27:24, with all other bits 0. With 64 locks this is 0x02000000.
- R6: After synchronous reset, every lock is free and `rdData` is 0.
- R7: A write of a nonzero value to a lock word leaves that lock unchanged. A write to the status word has no effect.
- R8: A lock is claimed only by an accepted read strobe. `rdData` changes only in the cycle after a read strobe and holds its value in between.
- R9: A read of an unmapped offset returns 0 and claims nothing. This covers a misaligned lock offset and a lock index at or above NUM_LOCKS.
- R10: A release write and a read strobe can reach the same lock word in one cycle. The release takes effect first, so the read returns 0 and the lock ends up taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte offset of the access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; on a lock word it claims the lock |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |

## Verification
Every result of this block is due exactly one clock edge after its strobe. Read data and the claim both land on the edge that samples `rdEn`, and a release lands on the edge that samples the write. The bench drives each access on a falling edge and lets the next rising edge capture it. It then compares `rdData` on the following falling edge, both against a literal expected value and against a behavioural lock model. The model is also compared on every idle cycle, which shows that `rdData` holds between reads. The state of a lock after a write or an ignored access is read back through a later lock read.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int LOCK_IDX_W    = 8;        // enough for 256 locks
  localparam int LOCK_BASE     = 'h800;
  localparam int STATUS_OFFSET = 'h014;
  localparam int CNT_LSB       = 24;
  localparam int DATA_W        = 32;

  typedef struct packed {
    logic                  rdAny;      // any accepted read strobe
    logic                  rdLock;     // read of a mapped lock word
    logic                  rdStatus;   // read of the status word
    logic                  wrRelease;  // zero write to a mapped lock word
    logic [LOCK_IDX_W-1:0] idx;        // lock index when mapped
  } lockStrb_t;
endpackage

// File: rtl/hwlock_ctrl.sv
module hwlock_ctrl
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS = 64,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output lockStrb_t         strb
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [ADDR_W-1:0] relOff;
  logic [WIDX_W-1:0] wordIdx;
  logic              lockHit;
  logic              statusHit;

  always_comb begin
    relOff    = addr - ADDR_W'(LOCK_BASE);
    wordIdx   = relOff[ADDR_W-1:2];
    lockHit   = (addr >= ADDR_W'(LOCK_BASE)) && (addr[1:0] == 2'b00) &&
                (wordIdx < WIDX_W'(NUM_LOCKS));
    statusHit = (addr == ADDR_W'(STATUS_OFFSET));
  end

  always_comb begin
    strb           = '0;
    strb.rdAny     = rdEn;
    strb.rdLock    = rdEn && lockHit;
    strb.rdStatus  = rdEn && statusHit;
    strb.wrRelease = wrEn && lockHit && (wrData == '0);
    strb.idx       = lockHit ? wordIdx[LOCK_IDX_W-1:0] : '0;
  end

  // R9: only one read target is ever selected
  assert_one_target_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.rdLock, strb.rdStatus}));

  // R8: no read-side strobe without the bus read strobe
  assert_claim_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> !strb.rdLock && !strb.rdStatus);

  // R7: a nonzero write never becomes a release
  assert_nonzero_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wrData != '0) |-> !strb.wrRelease);
endmodule

// File: rtl/hwlock_state.sv
module hwlock_state
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  lockStrb_t         strb,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] STATUS_WORD = DATA_W'(NUM_LOCKS / 32) << CNT_LSB;

  logic [NUM_LOCKS-1:0] lockQ;
  logic [NUM_LOCKS-1:0] lockD;
  logic [NUM_LOCKS-1:0] selVec;
  logic                 prevBit;
  logic [DATA_W-1:0]    rdNext;

  for (genvar gi = 0; gi < NUM_LOCKS; gi++) begin : gLock
    assign selVec[gi] = (strb.idx == LOCK_IDX_W'(gi));
    // release first, then claim
    assign lockD[gi]  = (lockQ[gi] && !(strb.wrRelease && selVec[gi])) ||
                        (strb.rdLock && selVec[gi]);
  end

  always_comb begin
    prevBit = strb.wrRelease ? 1'b0 : |(lockQ & selVec);
    if (strb.rdLock)        rdNext = {{(DATA_W-1){1'b0}}, prevBit};
    else if (strb.rdStatus) rdNext = STATUS_WORD;
    else                    rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockQ  <= '0;
      rdData <= '0;
    end else begin
      lockQ <= lockD;
      if (strb.rdAny) rdData <= rdNext;
    end
  end

  // R1/R2: a lock read leaves the addressed lock taken
  assert_claim_R1: assert property (@(posedge clk) disable iff (rst)
    strb.rdLock |=> ((lockQ & $past(selVec)) == $past(selVec)));

  // R3: a release without a same-cycle read frees the lock
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    strb.wrRelease && !strb.rdLock |=> ((lockQ & $past(selVec)) == '0));

  // R10: same-cycle release and read returns 0
  assert_write_first_R10: assert property (@(posedge clk) disable iff (rst)
    strb.wrRelease && strb.rdLock |=> (rdData == '0));

  // R8: lock state moves only on a claim or a release
  assert_no_side_effect_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.rdLock && !strb.wrRelease |=> $stable(lockQ));

  // R8: read data holds between reads
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.rdAny |=> $stable(rdData));
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int NUM_LOCKS = 64,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData
);
  if (!(NUM_LOCKS == 32 || NUM_LOCKS == 64 || NUM_LOCKS == 128 || NUM_LOCKS == 256))
  begin : gBadCount
    $error("NUM_LOCKS must be 32, 64, 128 or 256");
  end
  if (ADDR_W < 12) begin : gBadAddr
    $error("ADDR_W must be at least 12");
  end

  lockStrb_t strb;

  hwlock_ctrl #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .strb(strb)
  );

  hwlock_state #(.NUM_LOCKS(NUM_LOCKS)) uState (
    .clk(clk), .rst(rst), .strb(strb), .rdData(rdData)
  );

  // R6: reset clears read data
  assert_reset_R6: assert property (@(posedge clk) rst |=> (rdData == '0));

  // R5: status read returns the lock count field
  assert_status_R5: assert property (@(posedge clk) disable iff (rst)
    rdEn && (addr == ADDR_W'(STATUS_OFFSET)) |=>
      (rdData == (32'(NUM_LOCKS / 32) << CNT_LSB)));

  // R9: reads of unmapped words return 0
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    strb.rdAny && !strb.rdLock && !strb.rdStatus |=> (rdData == '0));
endmodule

// File: tb/tb_hwlock_bank.sv
module tb_hwlock_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM        = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;

  int  total = 0;
  int  fails = 0;
  bit  modelOn = 1'b0;
  bit  done = 1'b0;

  logic        refLocks [NUM];
  logic [31:0] refRd = '0;

  hwlock_bank #(.NUM_LOCKS(NUM), .ADDR_W(12)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lockOf(input logic [11:0] a);
    int off;
    off = int'(a) - 'h800;
    if (off < 0 || (off % 4) != 0 || (off / 4) >= NUM) return -1;
    return off / 4;
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one bus cycle; the model applies write first, then read
  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] wd, input logic re);
    int li;
    @(negedge clk);
    addr = a; wrEn = we; wrData = wd; rdEn = re;
    @(posedge clk);
    #1;
    li = lockOf(a);
    if (we && wd == 0 && li >= 0) refLocks[li] = 1'b0;
    if (re) begin
      if (li >= 0) begin
        refRd = {31'b0, refLocks[li]};
        refLocks[li] = 1'b1;
      end else if (a == 12'h014) refRd = 32'(NUM / 32) << 24;
      else refRd = '0;
    end
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic readExp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    step(a, 1'b0, 32'h0, 1'b1);
    @(negedge clk);
    checkVal(tag, rdData, exp);
  endtask

  // model compared on every cycle
  always @(negedge clk) begin
    if (modelOn && !rst) checkVal("R8 model", rdData, refRd);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM; i++) refLocks[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checkVal("R6 reset rdData", rdData, 32'h0);
    modelOn = 1'b1;

    readExp(12'h800, 32'h0, "R1 R6 first claim lock0");
    readExp(12'h800, 32'h1, "R2 reread taken lock0");
    step(12'h800, 1'b1, 32'h5, 1'b0);
    readExp(12'h800, 32'h1, "R7 nonzero write ignored");
    step(12'h800, 1'b1, 32'h0, 1'b0);
    readExp(12'h800, 32'h0, "R3 release then claim");
    readExp(12'h800, 32'h1, "R3 taken after claim");

    readExp(12'h014, 32'h0200_0000, "R5 status word");
    step(12'h014, 1'b1, 32'hFFFF_FFFF, 1'b0);
    readExp(12'h014, 32'h0200_0000, "R7 status write ignored");

    readExp(12'h100, 32'h0, "R9 unmapped offset");
    readExp(12'h900, 32'h0, "R9 index at NUM_LOCKS");
    readExp(12'h805, 32'h0, "R9 misaligned near lock1");
    readExp(12'h804, 32'h0, "R9 lock1 untouched by misaligned read");
    readExp(12'h804, 32'h1, "R2 lock1 now taken");

    // idle cycles: no claim without the read strobe, rdData holds
    @(negedge clk); addr = 12'h808;
    repeat (4) @(negedge clk);
    checkVal("R8 rdData held", rdData, 32'h1);
    readExp(12'h808, 32'h0, "R8 lock2 free after idle");

    readExp(12'h80C, 32'h0, "R1 claim lock3");
    step(12'h80C, 1'b1, 32'h0, 1'b1);
    @(negedge clk);
    checkVal("R10 write first read", rdData, 32'h0);
    readExp(12'h80C, 32'h1, "R10 lock ends taken");

    // address map sweep
    for (int i = 0; i < NUM; i++) step(12'(12'h800 + 4*i), 1'b1, 32'h0, 1'b0);
    for (int i = 0; i < NUM; i++) readExp(12'(12'h800 + 4*i), 32'h0, $sformatf("R4 lock %0d free", i));
    for (int i = 0; i < NUM; i++) readExp(12'(12'h800 + 4*i), 32'h1, $sformatf("R4 lock %0d taken", i));
    readExp(12'h8FC, 32'h1, "R4 last lock");

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule